// File: doc/BRIEF.md
# Redundant Receive Line Supervisor

This block sits between three redundant copies of a serial bus receive signal and the frame decoder. It picks one copy to forward and watches bus health with four nested timeouts, all scaled from one base period of `T_BASE` enable ticks. It moves the device into a safety state when communication has been lost. In automatic mode a timeout makes the block move to the next line and start a short hunt. The hunt keeps moving to the next line until that line shows enough edges to be believed alive. In a forced mode the chosen line is never changed.

A command byte written by the host sets the line mode, turns supervision off and holds a shared-peripheral lock flag with the number of its owner. A status byte reports the lock, the safety state, whether the three receive copies agree, and the index of the selected line. The INT output shows the safety state. When supervision is off, INT instead pulses once for each frame that addresses the device.

Top module: `ldiag_supervisor`

## Requirements
- R1: After a synchronous reset, `status` reads 0x00, `rx_idx` is 0 (automatic mode starting on line 0, supervision on, lock free), and `int_o` and `tri_evt` are 0.
- R2: Only cycles with `tick` high count toward a timeout. The short timeout fires on the T_BASE/16-th consecutive tick with `bus_dom` high. The medium timeout fires after T_BASE/4 ticks with no `frame_ok`. The long timeout fires after T_BASE ticks with no `frame_hit`. Each timeout counter restarts on the event it watches.
- R3: A write of `cmd_wdata` with `cmd_we` takes effect on the next cycle. The command layout is [2:0] mode, [3] supervision off, [6:4] owner number, [7] lock. Codes 0, 1 and 2 give automatic mode starting on that line. Codes 4, 5 and 6 force line 0, 1 or 2. Code 7 forces line 0. Code 3 updates bits [7:3] only and leaves both the mode and the selection unchanged. Writes are accepted whatever the state of the lock.
- R4: In automatic mode, every short, medium or long timeout moves `rx_idx` from 0 to 1, from 1 to 2 and from 2 back to 0. In a forced mode `rx_idx` changes only through a command write. `rx_idx` never reads 3.
- R5: A timeout that moves the selection starts a hunt. During the hunt the selection moves again every T_BASE/16 ticks. The hunt ends when 7 transitions have been seen on the selected input, and the selection then holds.
- R6: `status[1:0]` is the selected line index. `status[2]` is 1 one cycle after the three inputs are all 1 or all 0. `rx_out` is the selected input, registered once.
- R7: With supervision on, safety is entered after 4*T_BASE ticks without any `frame_hit` if no frame has addressed the device since reset. Otherwise it is entered when the long timeout fires. On entry `int_o` and `status[3]` go to 1, and `tri_evt` is high for exactly that one cycle.
- R8: Only `porta_wr` leaves the safety state. `status[3]` and INT return to 0 on the next cycle, and the exit takes priority over an entry in the same cycle.
- R9: With command bit 3 set, the safety state cannot be entered, and `int_o` goes high for one cycle after each `frame_hit`.
- R10: `status[7:4]` mirrors command bits [7:4].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timeout time-base enable |
| rx_in | input | 3 | Three redundant receive inputs |
| frame_ok | input | 1 | One-cycle strobe: a coherent frame seen on the bus |
| frame_hit | input | 1 | One-cycle strobe: a frame addressed this device |
| bus_dom | input | 1 | Bus currently at dominant level |
| porta_wr | input | 1 | One-cycle strobe: port A was written |
| cmd_we | input | 1 | Command byte write strobe |
| cmd_wdata | input | 8 | Command byte value |
| rx_out | output | 1 | Selected receive line, registered |
| rx_idx | output | 2 | Index of selected line |
| int_o | output | 1 | Safety / interrupt flag |
| tri_evt | output | 1 | One-cycle pulse on entry to safety |
| status | output | 8 | Status byte {lock, owner[2:0], safety, agree, idx[1:0]} |

## Verification
The bench goes after five corner cases. The first is the exact tick on which the short timeout and the hunt step fire. A counter off by one would move the line a cycle early or late. The second is the hunt ending after seven edges counted while `tick` is low. A design that gated edge counting with the tick would keep moving the selection. The third is the choice between the super-long and the long timeout before the first addressed frame. A design that used the long timeout there would enter safety after 64 ticks instead of 256. The last two are code 3 leaving the line alone and the case where entry and exit land in the same cycle. Mistakes there would show as a jump in `rx_idx` or a safety flag that stays set.

// File: rtl/ldiag_pkg.sv
package ldiag_pkg;
  typedef logic [1:0] sel_t;

  localparam logic [2:0] MODE_KEEP = 3'd3;

  function automatic sel_t next_line(input sel_t s);
    return (s == 2'd2) ? 2'd0 : s + 2'd1;
  endfunction

  function automatic sel_t code_line(input logic [2:0] code);
    return (code[1:0] == 2'd3) ? 2'd0 : code[1:0];
  endfunction
endpackage

// File: rtl/ldiag_timer.sv
module ldiag_timer #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic run,
  input  logic clr,
  output logic fire
);
  localparam int W = (LIMIT > 2) ? $clog2(LIMIT) : 1;

  logic [W-1:0] cnt;
  logic         last;

  assign last = (cnt == W'(LIMIT - 1));
  assign fire = run & tick & ~clr & last;

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (run && tick)
      cnt <= last ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/ldiag_linesel.sv
module ldiag_linesel
  import ldiag_pkg::*;
#(
  parameter int HUNT_LIM = 4,
  parameter int EDGE_N   = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic [2:0] rx_in,
  input  logic       load,
  input  sel_t       load_idx,
  input  logic       auto_en,
  input  logic       rot_req,
  output sel_t       sel,
  output logic       hunting
);
  localparam int EW = $clog2(EDGE_N + 1);

  logic [2:0]    rx_d;
  logic [EW-1:0] edges;
  logic          hunt_fire;
  logic          rot;
  logic          edge_seen;
  logic          hunt_clr;

  assign hunt_clr = ~hunting | load | rot_req;

  ldiag_timer #(.LIMIT(HUNT_LIM)) u_hunt (
    .clk  (clk),
    .rst  (rst),
    .tick (tick),
    .run  (hunting),
    .clr  (hunt_clr),
    .fire (hunt_fire)
  );

  assign rot       = auto_en & (rot_req | hunt_fire) & ~load;
  assign edge_seen = rx_in[sel] ^ rx_d[sel];

  always_ff @(posedge clk) begin
    rx_d <= rx_in;
    if (rst) begin
      sel     <= 2'd0;
      hunting <= 1'b0;
      edges   <= '0;
    end else if (load) begin
      sel     <= load_idx;
      hunting <= 1'b0;
      edges   <= '0;
    end else if (rot) begin
      sel     <= next_line(sel);
      hunting <= 1'b1;
      edges   <= '0;
    end else if (hunting && edge_seen) begin
      if (edges == EW'(EDGE_N - 1)) begin
        hunting <= 1'b0;
        edges   <= '0;
      end else begin
        edges <= edges + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ldiag_supervisor.sv
module ldiag_supervisor
  import ldiag_pkg::*;
#(
  parameter int T_BASE = 64,
  parameter int EDGE_N = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic [2:0] rx_in,
  input  logic       frame_ok,
  input  logic       frame_hit,
  input  logic       bus_dom,
  input  logic       porta_wr,
  input  logic       cmd_we,
  input  logic [7:0] cmd_wdata,
  output logic       rx_out,
  output logic [1:0] rx_idx,
  output logic       int_o,
  output logic       tri_evt,
  output logic [7:0] status
);
  localparam int SHORT_L = T_BASE / 16;
  localparam int MED_L   = T_BASE / 4;
  localparam int LONG_L  = T_BASE;
  localparam int SUPER_L = 4 * T_BASE;

  logic [7:0] cmd_q;
  logic       safe_q, acc_q, agree_q, rxo_q, int_q, evt_q;
  logic       f_short, f_med, f_long, f_super;
  logic       load, loss, set_safe, safe_nxt, hunting;
  sel_t       sel;

  ldiag_timer #(.LIMIT(SHORT_L)) u_short (
    .clk(clk), .rst(rst), .tick(tick), .run(bus_dom), .clr(~bus_dom), .fire(f_short));
  ldiag_timer #(.LIMIT(MED_L)) u_med (
    .clk(clk), .rst(rst), .tick(tick), .run(1'b1), .clr(frame_ok), .fire(f_med));
  ldiag_timer #(.LIMIT(LONG_L)) u_long (
    .clk(clk), .rst(rst), .tick(tick), .run(1'b1), .clr(frame_hit), .fire(f_long));
  ldiag_timer #(.LIMIT(SUPER_L)) u_super (
    .clk(clk), .rst(rst), .tick(tick), .run(1'b1), .clr(frame_hit), .fire(f_super));

  assign load = cmd_we & (cmd_wdata[2:0] != MODE_KEEP);

  ldiag_linesel #(.HUNT_LIM(SHORT_L), .EDGE_N(EDGE_N)) u_sel (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .rx_in    (rx_in),
    .load     (load),
    .load_idx (code_line(cmd_wdata[2:0])),
    .auto_en  (~cmd_q[2]),
    .rot_req  (f_short | f_med | f_long),
    .sel      (sel),
    .hunting  (hunting)
  );

  assign loss     = acc_q ? f_long : f_super;
  assign set_safe = ~safe_q & ~cmd_q[3] & loss & ~porta_wr;
  assign safe_nxt = porta_wr ? 1'b0 : (safe_q | set_safe);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q   <= 8'h00;
      safe_q  <= 1'b0;
      acc_q   <= 1'b0;
      agree_q <= 1'b0;
      rxo_q   <= 1'b0;
      int_q   <= 1'b0;
      evt_q   <= 1'b0;
    end else begin
      if (cmd_we) begin
        if (cmd_wdata[2:0] == MODE_KEEP) cmd_q[7:3] <= cmd_wdata[7:3];
        else                              cmd_q      <= cmd_wdata;
      end
      safe_q  <= safe_nxt;
      acc_q   <= acc_q | frame_hit;
      agree_q <= (&rx_in) | ~(|rx_in);
      rxo_q   <= rx_in[sel];
      int_q   <= safe_nxt | (cmd_q[3] & frame_hit);
      evt_q   <= set_safe;
    end
  end

  assign rx_out  = rxo_q;
  assign rx_idx  = sel;
  assign int_o   = int_q;
  assign tri_evt = evt_q;
  assign status  = {cmd_q[7:4], safe_q, agree_q, sel};
endmodule

// File: rtl/ldiag_supervisor_chk.sv
module ldiag_supervisor_chk (
  input logic       clk,
  input logic       rst,
  input logic       porta_wr,
  input logic       cmd_we,
  input logic       frame_hit,
  input logic       forced,
  input logic       surv_off,
  input logic [1:0] rx_idx,
  input logic       int_o,
  input logic       tri_evt,
  input logic [7:0] status
);
  p_idx_legal_r4: assert property (@(posedge clk) disable iff (rst)
    rx_idx != 2'd3);

  p_forced_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (forced && !cmd_we) |=> $stable(rx_idx));

  p_evt_single_r7: assert property (@(posedge clk) disable iff (rst)
    tri_evt |=> !tri_evt);

  p_evt_flags_r7: assert property (@(posedge clk) disable iff (rst)
    tri_evt |-> (int_o && status[3]));

  p_entry_evt_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(status[3]) |-> tri_evt);

  p_exit_r8: assert property (@(posedge clk) disable iff (rst)
    porta_wr |=> !status[3]);

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (status[3] && !porta_wr) |=> status[3]);

  p_nosafe_r9: assert property (@(posedge clk) disable iff (rst)
    (surv_off && !status[3]) |=> !status[3]);

  p_intpulse_r9: assert property (@(posedge clk) disable iff (rst)
    (surv_off && frame_hit) |=> int_o);
endmodule

bind ldiag_supervisor ldiag_supervisor_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .porta_wr  (porta_wr),
  .cmd_we    (cmd_we),
  .frame_hit (frame_hit),
  .forced    (cmd_q[2]),
  .surv_off  (cmd_q[3]),
  .rx_idx    (rx_idx),
  .int_o     (int_o),
  .tri_evt   (tri_evt),
  .status    (status)
);

// File: tb/ldiag_supervisor_tb.sv
module ldiag_supervisor_tb;
  localparam int CLK_NS = 10;
  localparam int TB     = 64;
  localparam int L_S    = TB / 16;
  localparam int L_M    = TB / 4;
  localparam int L_L    = TB;
  localparam int L_X    = 4 * TB;

  logic clk = 1'b0;
  logic rst, tick, frame_ok, frame_hit, bus_dom, porta_wr, cmd_we;
  logic [2:0] rx_in;
  logic [7:0] cmd_wdata;
  logic rx_out, int_o, tri_evt;
  logic [1:0] rx_idx;
  logic [7:0] status;

  always #(CLK_NS/2) clk = ~clk;

  ldiag_supervisor #(.T_BASE(TB), .EDGE_N(7)) u_dut (
    .clk(clk), .rst(rst), .tick(tick), .rx_in(rx_in), .frame_ok(frame_ok),
    .frame_hit(frame_hit), .bus_dom(bus_dom), .porta_wr(porta_wr),
    .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .rx_out(rx_out), .rx_idx(rx_idx),
    .int_o(int_o), .tri_evt(tri_evt), .status(status));

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // behavioural reference state
  int m_cmd, m_sel, m_safe, m_acc, m_hunt, m_edges, m_int, m_evt, m_rxo, m_agree;
  int c_s, c_m, c_l, c_x, c_h;
  logic [2:0] m_rxd;

  function automatic int bump(int c, int lim, bit run, bit clr, bit tk);
    if (clr) return 0;
    if (run && tk) return (c == lim - 1) ? 0 : c + 1;
    return c;
  endfunction

  task automatic model_step();
    bit fs, fm, fl, fx, fh, hclr, ld, rot, edg, loss, setx;
    int nsafe, code;
    if (rst) begin
      m_cmd = 0; m_sel = 0; m_safe = 0; m_acc = 0; m_hunt = 0; m_edges = 0;
      m_int = 0; m_evt = 0; m_rxo = 0; m_agree = 0;
      c_s = 0; c_m = 0; c_l = 0; c_x = 0; c_h = 0;
      m_rxd = rx_in;
      return;
    end
    code = int'(cmd_wdata[2:0]);
    fs = bus_dom && tick && (c_s == L_S - 1);
    fm = !frame_ok && tick && (c_m == L_M - 1);
    fl = !frame_hit && tick && (c_l == L_L - 1);
    fx = !frame_hit && tick && (c_x == L_X - 1);
    ld = cmd_we && (code != 3);
    hclr = (m_hunt == 0) || ld || fs || fm || fl;
    fh = (m_hunt != 0) && tick && !hclr && (c_h == L_S - 1);
    rot = (((m_cmd >> 2) & 1) == 0) && (fs || fm || fl || fh) && !ld;
    edg = rx_in[m_sel] != m_rxd[m_sel];
    c_s = bump(c_s, L_S, bus_dom, !bus_dom, tick);
    c_m = bump(c_m, L_M, 1, frame_ok, tick);
    c_l = bump(c_l, L_L, 1, frame_hit, tick);
    c_x = bump(c_x, L_X, 1, frame_hit, tick);
    c_h = bump(c_h, L_S, m_hunt != 0, hclr, tick);
    loss = m_acc ? fl : fx;
    setx = (m_safe == 0) && (((m_cmd >> 3) & 1) == 0) && loss && !porta_wr;
    nsafe = porta_wr ? 0 : ((m_safe != 0 || setx) ? 1 : 0);
    m_int = (nsafe != 0 || ((((m_cmd >> 3) & 1) != 0) && frame_hit)) ? 1 : 0;
    m_evt = setx ? 1 : 0;
    m_rxo = rx_in[m_sel];
    m_agree = (rx_in == 3'b111 || rx_in == 3'b000) ? 1 : 0;
    if (ld) begin
      m_sel = ((code % 4) == 3) ? 0 : (code % 4); m_hunt = 0; m_edges = 0;
    end else if (rot) begin
      m_sel = (m_sel + 1) % 3; m_hunt = 1; m_edges = 0;
    end else if (m_hunt != 0 && edg) begin
      if (m_edges == 6) begin m_hunt = 0; m_edges = 0; end
      else m_edges = m_edges + 1;
    end
    if (cmd_we) begin
      if (code == 3) m_cmd = (m_cmd & 7) | (int'(cmd_wdata) & 8'hF8);
      else m_cmd = int'(cmd_wdata);
    end
    m_safe = nsafe;
    if (frame_hit) m_acc = 1;
    m_rxd = rx_in;
  endtask

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R4 R5 rx_idx", int'(rx_idx), m_sel);
    chk("R6 rx_out", int'(rx_out), m_rxo);
    chk("R7 R8 R9 int_o", int'(int_o), m_int);
    chk("R7 tri_evt", int'(tri_evt), m_evt);
    chk("R3 R6 R7 R10 status", int'(status),
        ((m_cmd & 8'hF0) | (m_safe << 3) | (m_agree << 2) | m_sel));
  endtask

  task automatic cyc();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic pulse_frame();
    frame_ok = 1; frame_hit = 1; cyc(); frame_ok = 0; frame_hit = 0;
  endtask

  task automatic wr_cmd(logic [7:0] v);
    cmd_we = 1; cmd_wdata = v; cyc(); cmd_we = 0; cmd_wdata = 0;
  endtask

  task automatic pa_wr();
    porta_wr = 1; cyc(); porta_wr = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    rst = 1; tick = 1; frame_ok = 0; frame_hit = 0; bus_dom = 0; porta_wr = 0;
    cmd_we = 0; cmd_wdata = 0; rx_in = 3'b000;
    @(negedge clk);
    idle(3);
    rst = 0;
    // R1: reset state
    chk("R1 status", int'(status), 0);
    chk("R1 rx_idx", int'(rx_idx), 0);
    chk("R1 int_o", int'(int_o), 0);
    // healthy traffic
    for (int i = 0; i < 5; i++) begin idle(7); pulse_frame(); end
    // R2: short timeout on the 4th dominant tick
    bus_dom = 1;
    idle(3);
    chk("R2 no early short timeout", int'(rx_idx), 0);
    idle(1);
    chk("R2 R4 short timeout moves line", int'(rx_idx), 1);
    bus_dom = 0;
    // R5: hunt steps every T/16 ticks
    idle(4);
    chk("R5 hunt step", int'(rx_idx), 2);
    // R5: seven edges with tick low end the hunt
    tick = 0;
    for (int i = 0; i < 7; i++) begin rx_in = ~rx_in; cyc(); end
    tick = 1;
    idle(5); pulse_frame(); idle(5); pulse_frame();
    chk("R5 hunt ended, line holds", int'(rx_idx), 2);
    // R7: loss of addressed frames after first access
    idle(80);
    chk("R7 safety after long timeout", int'(status[3]), 1);
    chk("R7 int high in safety", int'(int_o), 1);
    // R8: port A write exits
    pa_wr();
    chk("R8 exit safety", int'(status[3]), 0);
    chk("R8 int cleared", int'(int_o), 0);
    // R3/R4: forced line
    wr_cmd(8'h05);
    chk("R3 force line 1", int'(rx_idx), 1);
    idle(100);
    chk("R4 forced line holds", int'(rx_idx), 1);
    pa_wr();
    wr_cmd(8'hB3);
    chk("R3 code 3 keeps line", int'(rx_idx), 1);
    chk("R10 owner and lock", int'(status[7:4]), 4'hB);
    wr_cmd(8'h07);
    chk("R3 code 7 forces line 0", int'(rx_idx), 0);
    // R9: supervision off
    wr_cmd(8'h08);
    pa_wr();
    idle(300);
    chk("R9 no safety when off", int'(status[3]), 0);
    frame_hit = 1; cyc(); frame_hit = 0;
    chk("R9 int pulse", int'(int_o), 1);
    cyc();
    chk("R9 int pulse ends", int'(int_o), 0);
    // R6: agreement flag
    rx_in = 3'b111; cyc();
    chk("R6 agree all ones", int'(status[2]), 1);
    rx_in = 3'b010; cyc();
    chk("R6 disagree", int'(status[2]), 0);
    rx_in = 3'b000; cyc();
    chk("R6 agree all zeros", int'(status[2]), 1);
    // mixed stimulus against the reference model
    wr_cmd(8'h00);
    for (int i = 0; i < 3000; i++) begin
      tick      = ($urandom % 2) == 0;
      frame_ok  = ($urandom % 23) == 0;
      frame_hit = frame_ok && (($urandom % 3) == 0);
      bus_dom   = ($urandom % 5) != 0;
      porta_wr  = ($urandom % 97) == 0;
      cmd_we    = ($urandom % 150) == 0;
      cmd_wdata = 8'($urandom);
      rx_in     = 3'($urandom);
      cyc();
    end
    tick = 1; frame_ok = 0; frame_hit = 0; bus_dom = 0; porta_wr = 0;
    cmd_we = 0; cmd_wdata = 0;
    // R7: super-long timeout before first access
    rst = 1; idle(2); rst = 0;
    idle(200);
    chk("R7 no safety before super-long", int'(status[3]), 0);
    idle(70);
    chk("R7 safety after super-long", int'(status[3]), 1);
    finish_run();
  end
endmodule